// File: doc/BRIEF.md
# Four-Phase Register Bus Slave

This block is an 8-bit register slave for a simple synchronous processor bus with a 4-bit address, separate write-data and read-data buses, a read/write level, a select and a transfer acknowledge. The handshake is fully interlocked. The master raises select with address, direction and write data held steady. The slave performs the access and raises acknowledge. The master then drops select, and the slave drops acknowledge once it sees select low. Because of this the master may run on a different clock. Select passes through a synchronizer before the slave acts on it.

The slave holds the configuration and event registers for two datapath sides, called the transmit side and the receive side. Each side has an enable bit, a live lock-status bit, a two-bit sticky event register that clears when read, and a matching two-bit event-enable mask. The transmit side also has two outbound overhead bits. The receive side reports two captured overhead bits. A pair of 8-bit fill thresholds serves a downstream rate controller. The interrupt request output combines both sides. When the slave is idle, read data and acknowledge are both zero, so several slaves can share the bus through a plain OR.

Top module: `fourphase_regslv`

## Requirements
- R1: After reset, bus_ack, bus_rdata and irq are 0. Every writable field is 0, except the upper threshold (reset 24) and the lower threshold (reset 8).
- R2: The map is as follows. 0x0 holds tx enable (bit0, RW). 0x1 holds rx enable (bit0, RW). 0x2 holds tx lock (bit0, RO). 0x3 holds rx lock (bit0, RO). 0x4 holds the tx event mask (bits1:0, RW). 0x5 holds the rx event mask (bits1:0, RW). 0x6 holds the tx events (bits1:0). 0x7 holds the rx events (bits1:0). 0x8 holds the tx overhead out (bits1:0, RW). 0x9 holds the rx overhead in (bits1:0, RO). 0xA holds the upper threshold (bits7:0, RW). 0xB holds the lower threshold (bits7:0, RW). Bits outside these fields read as 0.
- R3: With bus_rd high the access returns the addressed register on bus_rdata and changes nothing except as R8 states. With bus_rd low, bus_wdata is written into the addressed RW field.
- R4: bus_ack rises on the third clk rising edge after bus_sel is raised. It stays high while bus_sel is high, and falls on the third rising edge after bus_sel drops.
- R5: bus_rdata is 0 whenever bus_ack is 0. During a read with bus_ack high, it carries the value sampled when the access took place.
- R6: Exactly one access is performed per handshake, however long bus_sel is held. A select held high does not repeat a write or a clear.
- R7: A one-cycle pulse on tx_evt_i[i] or rx_evt_i[i] sets event bit i of that side, and the bit stays set until cleared. Bit 1 means a FIFO overflow or underflow. Bit 0 means an unhandled strobe pattern.
- R8: Reading an event register returns its bits and clears them, on the clock edge where bus_ack rises. Writing an event register has no effect.
- R9: An event pulse present on the same edge as the clear is kept set.
- R10: irq is high whenever any event bit is set while its mask bit is also set, on either side.
- R11: Reads of 0x2, 0x3 and 0x9 return the live inputs tx_lock_i, rx_lock_i and rx_ovh_i. Writes to those addresses have no effect.
- R12: Accesses to 0xC to 0xF are acknowledged, read as 0, and change no register.
- R13: tx_en_o, rx_en_o, tx_ovh_o, fill_hi_o and fill_lo_o always show the current contents of their registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slave clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Select from the bus master (may be asynchronous) |
| bus_rd | input | 1 | 1 = read, 0 = write |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, zero when not acknowledging |
| bus_ack | output | 1 | Transfer acknowledge, held until select drops |
| irq | output | 1 | Interrupt request |
| tx_lock_i | input | 1 | Transmit-side lock status |
| rx_lock_i | input | 1 | Receive-side lock status |
| tx_evt_i | input | 2 | Transmit-side event pulses |
| rx_evt_i | input | 2 | Receive-side event pulses |
| rx_ovh_i | input | 2 | Receive-side captured overhead bits |
| tx_en_o | output | 1 | Transmit-side enable |
| rx_en_o | output | 1 | Receive-side enable |
| tx_ovh_o | output | 2 | Transmit-side overhead bits to insert |
| fill_hi_o | output | 8 | Upper fill threshold |
| fill_lo_o | output | 8 | Lower fill threshold |

## Verification
Several properties are checked on every cycle. Acknowledge holds while the synchronized select is high. Read data is zero whenever acknowledge is low. An access pulse never repeats inside a handshake. An event pulse always leaves its bit set. A clean read of the event register empties it. The irq output stays low with both masks at zero. Other behaviour can only be shown by the bench scenarios: the exact three-edge latency in each direction, the read-back value of each field, a clear that collides with an event on the same edge, and the irq level against a model of the enabled event bits across random traffic.

// File: rtl/regslv_pkg.sv
package regslv_pkg;

  localparam int REG_AW = 4;
  localparam int EVT_W  = 2;
  localparam int OVH_W  = 2;

  localparam logic [REG_AW-1:0] A_TX_CTRL = 4'h0;
  localparam logic [REG_AW-1:0] A_RX_CTRL = 4'h1;
  localparam logic [REG_AW-1:0] A_TX_STAT = 4'h2;
  localparam logic [REG_AW-1:0] A_RX_STAT = 4'h3;
  localparam logic [REG_AW-1:0] A_TX_MASK = 4'h4;
  localparam logic [REG_AW-1:0] A_RX_MASK = 4'h5;
  localparam logic [REG_AW-1:0] A_TX_EVT  = 4'h6;
  localparam logic [REG_AW-1:0] A_RX_EVT  = 4'h7;
  localparam logic [REG_AW-1:0] A_TX_OVH  = 4'h8;
  localparam logic [REG_AW-1:0] A_RX_OVH  = 4'h9;
  localparam logic [REG_AW-1:0] A_FILL_HI = 4'hA;
  localparam logic [REG_AW-1:0] A_FILL_LO = 4'hB;

  typedef enum logic {HS_IDLE = 1'b0, HS_HOLD = 1'b1} hs_state_t;

  // Next value of one sticky event bit: a new event wins over a clear.
  function automatic logic evt_bit_next(input logic cur, input logic clr, input logic evt);
    return evt | (cur & ~clr);
  endfunction

  // Any event bit that is set and unmasked.
  function automatic logic evt_pending(input logic [EVT_W-1:0] evts,
                                       input logic [EVT_W-1:0] mask);
    return |(evts & mask);
  endfunction

endpackage

// File: rtl/regslv_sync.sv
module regslv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_async,
  output logic q_sync
);
  logic [STAGES-1:0] chain;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d_async;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/regslv_hshk.sv
module regslv_hshk
  import regslv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_sync,
  output logic acc_pulse,
  output logic ack
);
  hs_state_t state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= HS_IDLE;
    end else begin
      unique case (state)
        HS_IDLE: if (sel_sync)  state <= HS_HOLD;
        HS_HOLD: if (!sel_sync) state <= HS_IDLE;
        default: state <= HS_IDLE;
      endcase
    end
  end

  // The access is performed once, on the edge that moves IDLE to HOLD.
  assign acc_pulse = (state == HS_IDLE) && sel_sync;
  assign ack       = (state == HS_HOLD);
endmodule

// File: rtl/regslv_isr.sv
module regslv_isr
  import regslv_pkg::*;
#(
  parameter int W = EVT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt,
  input  logic         clr,
  output logic [W-1:0] bits
);
  generate
    genvar b;
    for (b = 0; b < W; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bits[b] <= 1'b0;
        else        bits[b] <= evt_bit_next(bits[b], clr, evt[b]);
      end
    end
  endgenerate
endmodule

// File: rtl/fourphase_regslv.sv
module fourphase_regslv
  import regslv_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int HI_RST      = 24,
  parameter int LO_RST      = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_rd,
  input  logic [REG_AW-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ack,
  output logic              irq,
  input  logic              tx_lock_i,
  input  logic              rx_lock_i,
  input  logic [EVT_W-1:0]  tx_evt_i,
  input  logic [EVT_W-1:0]  rx_evt_i,
  input  logic [OVH_W-1:0]  rx_ovh_i,
  output logic              tx_en_o,
  output logic              rx_en_o,
  output logic [OVH_W-1:0]  tx_ovh_o,
  output logic [DATA_W-1:0] fill_hi_o,
  output logic [DATA_W-1:0] fill_lo_o
);
  localparam logic [DATA_W-1:0] HI_INIT = DATA_W'(HI_RST);
  localparam logic [DATA_W-1:0] LO_INIT = DATA_W'(LO_RST);

  // Named internal events, visible to the bound checker.
  logic              sel_sync;
  logic              acc_pulse;
  logic              wr_pulse;
  logic              rd_pulse;
  logic              tx_clr;
  logic              rx_clr;
  logic [EVT_W-1:0]  tx_isr;
  logic [EVT_W-1:0]  rx_isr;
  logic [EVT_W-1:0]  tx_ien;
  logic [EVT_W-1:0]  rx_ien;
  logic              tx_en_q;
  logic              rx_en_q;
  logic [OVH_W-1:0]  tx_ovh_q;
  logic [DATA_W-1:0] hi_q;
  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rdata_q;

  regslv_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (bus_sel),
    .q_sync  (sel_sync)
  );

  regslv_hshk u_hshk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_sync  (sel_sync),
    .acc_pulse (acc_pulse),
    .ack       (bus_ack)
  );

  assign wr_pulse = acc_pulse & ~bus_rd;
  assign rd_pulse = acc_pulse &  bus_rd;
  assign tx_clr   = rd_pulse & (bus_addr == A_TX_EVT);
  assign rx_clr   = rd_pulse & (bus_addr == A_RX_EVT);

  regslv_isr #(.W(EVT_W)) u_tx_isr (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (tx_evt_i),
    .clr   (tx_clr),
    .bits  (tx_isr)
  );

  regslv_isr #(.W(EVT_W)) u_rx_isr (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (rx_evt_i),
    .clr   (rx_clr),
    .bits  (rx_isr)
  );

  // Writable fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_q  <= 1'b0;
      rx_en_q  <= 1'b0;
      tx_ien   <= '0;
      rx_ien   <= '0;
      tx_ovh_q <= '0;
      hi_q     <= HI_INIT;
      lo_q     <= LO_INIT;
    end else if (wr_pulse) begin
      unique case (bus_addr)
        A_TX_CTRL: tx_en_q  <= bus_wdata[0];
        A_RX_CTRL: rx_en_q  <= bus_wdata[0];
        A_TX_MASK: tx_ien   <= bus_wdata[EVT_W-1:0];
        A_RX_MASK: rx_ien   <= bus_wdata[EVT_W-1:0];
        A_TX_OVH:  tx_ovh_q <= bus_wdata[OVH_W-1:0];
        A_FILL_HI: hi_q     <= bus_wdata;
        A_FILL_LO: lo_q     <= bus_wdata;
        default: ;
      endcase
    end
  end

  // Read selection, with unused bits at zero
  always_comb begin
    rd_mux = '0;
    unique case (bus_addr)
      A_TX_CTRL: rd_mux[0]         = tx_en_q;
      A_RX_CTRL: rd_mux[0]         = rx_en_q;
      A_TX_STAT: rd_mux[0]         = tx_lock_i;
      A_RX_STAT: rd_mux[0]         = rx_lock_i;
      A_TX_MASK: rd_mux[EVT_W-1:0] = tx_ien;
      A_RX_MASK: rd_mux[EVT_W-1:0] = rx_ien;
      A_TX_EVT:  rd_mux[EVT_W-1:0] = tx_isr;
      A_RX_EVT:  rd_mux[EVT_W-1:0] = rx_isr;
      A_TX_OVH:  rd_mux[OVH_W-1:0] = tx_ovh_q;
      A_RX_OVH:  rd_mux[OVH_W-1:0] = rx_ovh_i;
      A_FILL_HI: rd_mux            = hi_q;
      A_FILL_LO: rd_mux            = lo_q;
      default:   rd_mux            = '0;
    endcase
  end

  // Read data is captured once at the access edge and cleared at release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (rd_pulse)  rdata_q <= rd_mux;
    else if (wr_pulse)  rdata_q <= '0;
    else if (!bus_ack)  rdata_q <= '0;
  end

  assign bus_rdata = bus_ack ? rdata_q : '0;
  assign irq       = evt_pending(tx_isr, tx_ien) | evt_pending(rx_isr, rx_ien);

  assign tx_en_o   = tx_en_q;
  assign rx_en_o   = rx_en_q;
  assign tx_ovh_o  = tx_ovh_q;
  assign fill_hi_o = hi_q;
  assign fill_lo_o = lo_q;
endmodule

// File: rtl/regslv_chk.sv
module regslv_chk
  import regslv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_sync,
  input logic              acc_pulse,
  input logic              bus_ack,
  input logic              bus_rd,
  input logic [REG_AW-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [EVT_W-1:0]  tx_evt_i,
  input logic [EVT_W-1:0]  tx_isr,
  input logic [EVT_W-1:0]  tx_ien,
  input logic [EVT_W-1:0]  rx_ien,
  input logic              irq
);
  // R4
  ack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_ack && sel_sync) |=> bus_ack);

  // R4
  ack_after_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(acc_pulse));

  // R5
  rdata_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ack |-> (bus_rdata == '0));

  // R6
  single_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_pulse |-> !bus_ack);

  // R7
  event_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_evt_i != '0) |=> ((tx_isr & $past(tx_evt_i)) == $past(tx_evt_i)));

  // R8
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_pulse && bus_rd && (bus_addr == A_TX_EVT) && (tx_evt_i == '0)) |=> (tx_isr == '0));

  // R10
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((tx_ien == '0) && (rx_ien == '0)) |-> !irq);
endmodule

bind fourphase_regslv regslv_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .sel_sync  (sel_sync),
  .acc_pulse (acc_pulse),
  .bus_ack   (bus_ack),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .tx_evt_i  (tx_evt_i),
  .tx_isr    (tx_isr),
  .tx_ien    (tx_ien),
  .rx_ien    (rx_ien),
  .irq       (irq)
);

// File: tb/fourphase_regslv_tb_top.sv
module fourphase_regslv_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       bus_ack;
  logic       irq;
  logic       tx_lock_i = 1'b0;
  logic       rx_lock_i = 1'b0;
  logic [1:0] tx_evt_i = '0;
  logic [1:0] rx_evt_i = '0;
  logic [1:0] rx_ovh_i = '0;
  logic       tx_en_o;
  logic       rx_en_o;
  logic [1:0] tx_ovh_o;
  logic [7:0] fill_hi_o;
  logic [7:0] fill_lo_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model of the register contents
  logic       m_tx_en, m_rx_en;
  logic [1:0] m_tx_ien, m_rx_ien, m_tx_isr, m_rx_isr, m_tx_ovh;
  logic [7:0] m_hi, m_lo;

  always #2 clk = ~clk;

  fourphase_regslv dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_ack(bus_ack), .irq(irq), .tx_lock_i(tx_lock_i), .rx_lock_i(rx_lock_i),
    .tx_evt_i(tx_evt_i), .rx_evt_i(rx_evt_i), .rx_ovh_i(rx_ovh_i),
    .tx_en_o(tx_en_o), .rx_en_o(rx_en_o), .tx_ovh_o(tx_ovh_o),
    .fill_hi_o(fill_hi_o), .fill_lo_o(fill_lo_o)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [3:0] a);
    case (a)
      4'h0: return {7'd0, m_tx_en};
      4'h1: return {7'd0, m_rx_en};
      4'h2: return {7'd0, tx_lock_i};
      4'h3: return {7'd0, rx_lock_i};
      4'h4: return {6'd0, m_tx_ien};
      4'h5: return {6'd0, m_rx_ien};
      4'h6: return {6'd0, m_tx_isr};
      4'h7: return {6'd0, m_rx_isr};
      4'h8: return {6'd0, m_tx_ovh};
      4'h9: return {6'd0, rx_ovh_i};
      4'hA: return m_hi;
      4'hB: return m_lo;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic exp_irq();
    return |(m_tx_isr & m_tx_ien) || |(m_rx_isr & m_rx_ien);
  endfunction

  task automatic model_write(input logic [3:0] a, input logic [7:0] d);
    case (a)
      4'h0: m_tx_en  = d[0];
      4'h1: m_rx_en  = d[0];
      4'h4: m_tx_ien = d[1:0];
      4'h5: m_rx_ien = d[1:0];
      4'h8: m_tx_ovh = d[1:0];
      4'hA: m_hi     = d;
      4'hB: m_lo     = d;
      default: ;
    endcase
  endtask

  // One full four-phase handshake. edge_evt is driven on tx_evt_i so that it
  // is present on the access edge; hold_evt is pulsed while select is held.
  task automatic xfer(input logic rd, input logic [3:0] a, input logic [7:0] wd,
                      input logic [1:0] edge_evt, input int hold, input logic [1:0] hold_evt,
                      output logic [7:0] rdv, output int up_lat, output int dn_lat);
    @(negedge clk);
    bus_addr = a; bus_rd = rd; bus_wdata = wd; bus_sel = 1'b1;
    up_lat = 0;
    do begin
      @(negedge clk);
      up_lat++;
      if (up_lat == 2) tx_evt_i = edge_evt;
      else             tx_evt_i = '0;
    end while (!bus_ack && up_lat < 20);
    tx_evt_i = '0;
    m_tx_isr = m_tx_isr | edge_evt;
    rdv = bus_rdata;
    for (int i = 0; i < hold; i++) begin
      tx_evt_i = (i == 1) ? hold_evt : 2'b00;
      @(negedge clk);
      chk(bus_ack == 1'b1, "R4 ack held", bus_ack, 1);
    end
    if (hold > 1) m_tx_isr = m_tx_isr | hold_evt;
    tx_evt_i = '0;
    bus_sel = 1'b0;
    dn_lat = 0;
    do begin
      @(negedge clk);
      dn_lat++;
    end while (bus_ack && dn_lat < 20);
    chk(bus_rdata == 8'h00, "R5 rdata idle", bus_rdata, 0);
  endtask

  // Simple access with model update and checks of data and outputs.
  task automatic acc(input logic rd, input logic [3:0] a, input logic [7:0] wd, input string req);
    logic [7:0] rdv, expv;
    int ul, dl;
    expv = exp_read(a);
    xfer(rd, a, wd, 2'b00, 0, 2'b00, rdv, ul, dl);
    if (rd) begin
      chk(rdv == expv, req, rdv, expv);
      if (a == 4'h6) m_tx_isr = '0;
      if (a == 4'h7) m_rx_isr = '0;
    end else begin
      model_write(a, wd);
    end
    chk(irq == exp_irq(), "R10 irq", irq, exp_irq());
    chk({tx_en_o, rx_en_o, tx_ovh_o, fill_hi_o, fill_lo_o} ==
        {m_tx_en, m_rx_en, m_tx_ovh, m_hi, m_lo}, "R13 outputs",
        {tx_en_o, rx_en_o, tx_ovh_o, fill_hi_o, fill_lo_o},
        {m_tx_en, m_rx_en, m_tx_ovh, m_hi, m_lo});
  endtask

  task automatic pulse(input logic [1:0] te, input logic [1:0] re);
    @(negedge clk);
    tx_evt_i = te; rx_evt_i = re;
    @(negedge clk);
    tx_evt_i = '0; rx_evt_i = '0;
    m_tx_isr = m_tx_isr | te;
    m_rx_isr = m_rx_isr | re;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R4 handshake hung actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rdv;
    int ul, dl;
    void'($urandom(32'd20250611));
    m_tx_en = 0; m_rx_en = 0; m_tx_ien = 0; m_rx_ien = 0;
    m_tx_isr = 0; m_rx_isr = 0; m_tx_ovh = 0; m_hi = 8'd24; m_lo = 8'd8;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(bus_ack == 0 && bus_rdata == 0 && irq == 0, "R1 reset outputs",
        {bus_ack, irq, bus_rdata}, 0);
    chk({fill_hi_o, fill_lo_o} == {8'd24, 8'd8}, "R1 threshold reset", {fill_hi_o, fill_lo_o}, {8'd24, 8'd8});
    for (int a = 0; a < 12; a++) acc(1'b1, 4'(a), 8'h00, "R1 reset read");

    // R4 latency in each direction
    xfer(1'b1, 4'hA, 8'h00, 2'b00, 0, 2'b00, rdv, ul, dl);
    chk(ul == 3, "R4 ack rise latency", ul, 3);
    chk(dl == 3, "R4 ack fall latency", dl, 3);
    chk(rdv == 8'd24, "R5 read data during ack", rdv, 24);

    // R2 R3 write and read back each RW field, unused bits read 0
    for (int a = 0; a < 12; a++) acc(1'b0, 4'(a), 8'hFF, "R3 write");
    for (int a = 0; a < 12; a++) acc(1'b1, 4'(a), 8'h00, "R2 readback all ones");
    for (int a = 0; a < 12; a++) acc(1'b0, 4'(a), 8'h5A, "R3 write");
    for (int a = 0; a < 12; a++) acc(1'b1, 4'(a), 8'h00, "R2 readback pattern");

    // R11 read-only live inputs
    tx_lock_i = 1; rx_lock_i = 0; rx_ovh_i = 2'b10;
    acc(1'b0, 4'h2, 8'h00, "R11 write stat");
    acc(1'b0, 4'h9, 8'hFF, "R11 write ovh in");
    acc(1'b1, 4'h2, 8'h00, "R11 tx lock");
    acc(1'b1, 4'h3, 8'h00, "R11 rx lock");
    acc(1'b1, 4'h9, 8'h00, "R11 rx ovh");

    // R12 unused addresses
    for (int a = 12; a < 16; a++) begin
      xfer(1'b0, 4'(a), 8'hFF, 2'b00, 0, 2'b00, rdv, ul, dl);
      chk(ul == 3, "R12 unused write acked", ul, 3);
      xfer(1'b1, 4'(a), 8'h00, 2'b00, 0, 2'b00, rdv, ul, dl);
      chk(rdv == 8'h00 && ul == 3, "R12 unused read zero", {ul[7:0], rdv}, 16'h0300);
    end
    for (int a = 0; a < 12; a++) acc(1'b1, 4'(a), 8'h00, "R12 no side effect");

    // R7 R8 R10 events, masks, read-clear, writes ignored
    acc(1'b0, 4'h4, 8'h00, "R10 mask off");
    acc(1'b0, 4'h5, 8'h00, "R10 mask off");
    pulse(2'b10, 2'b01);
    chk(irq == 0, "R10 masked events no irq", irq, 0);
    acc(1'b0, 4'h6, 8'h00, "R8 write isr ignored");
    acc(1'b1, 4'h6, 8'h00, "R7 tx fifo event bit1");
    acc(1'b1, 4'h6, 8'h00, "R8 cleared after read");
    acc(1'b0, 4'h5, 8'h01, "R10 rx mask bit0");
    chk(irq == 1, "R10 enabled event raises irq", irq, 1);
    acc(1'b1, 4'h7, 8'h00, "R7 rx strobe event bit0");
    chk(irq == 0, "R10 irq drops after clear", irq, 0);

    // R9 event on the clearing edge survives
    pulse(2'b01, 2'b00);
    xfer(1'b1, 4'h6, 8'h00, 2'b10, 0, 2'b00, rdv, ul, dl);
    chk(rdv == 8'h01, "R9 read value before collision", rdv, 1);
    m_tx_isr = 2'b10;
    acc(1'b1, 4'h6, 8'h00, "R9 colliding event kept");

    // R6 long hold: one clear only, a later event persists; one write only
    pulse(2'b10, 2'b00);
    xfer(1'b1, 4'h6, 8'h00, 2'b00, 8, 2'b01, rdv, ul, dl);
    chk(rdv == 8'h02, "R6 read during long hold", rdv, 2);
    m_tx_isr = 2'b01;
    acc(1'b1, 4'h6, 8'h00, "R6 no second clear");

    // Random traffic
    for (int n = 0; n < 400; n++) begin
      logic [3:0] a;
      logic r;
      if ($urandom_range(3) == 0) pulse(2'($urandom), 2'($urandom));
      tx_lock_i = 1'($urandom); rx_lock_i = 1'($urandom); rx_ovh_i = 2'($urandom);
      a = 4'($urandom);
      r = 1'($urandom);
      acc(r, a, 8'($urandom), r ? "R3 random read" : "R3 random write");
    end

    finish_run();
  end
endmodule